// File: doc/BRIEF.md
# Load/Store Data Watchpoint Comparator

The block observes the core's load/store data path one transfer per cycle. Each transfer is judged by one address comparator and two data comparators. When every enabled comparator is satisfied, the block produces a single-cycle watchpoint event and advances an event counter. Because the address comparator drops the low address bits that lie inside the transfer's width, a byte or half-word target is still caught when a wider load or store carries it.

Every transfer carries an instruction tag. A string or multiple transfer, or a word that satisfies a byte condition on several lanes, can match many times within one instruction. All of those matches collapse into one event and one count step for that instruction. The two data comparators can be set with opposite ordering conditions to form an unsigned value window, for example a byte strictly between 0x07 and 0x0C.

Top module: `ls_wp_cmp`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, wp_o is 0 and wp_cnt_o is 0. Reset does not enable any comparator on its own.
- R2: If the address comparator and both data comparators are disabled, no transfer raises wp_o.
- R3: Condition codes are 0 equal, 1 not equal, 2 greater than, 3 less than. They are unsigned and compare the transfer's value against the programmed value, so "greater than" means the transfer is larger.
- R4: Size codes are 0 byte, 1 half-word and 2 or 3 word. A word transfer ignores address bits [1:0] on both sides of the address comparison. A half-word transfer ignores bit [0]. A byte transfer compares every address bit.
- R5: Data lane i is bits [8i+7:8i], and mask bit i enables lane i. Only the enabled lanes are compared, as one unsigned value. An enabled data comparator with an all-zero mask is satisfied.
- R6: A transfer matches only when acc_valid_i is 1, at least one comparator is enabled, and every enabled comparator is satisfied. A disabled comparator counts as satisfied. Two data comparators set to greater than and less than form an open window.
- R7: A byte target on lane 2 or a half-word target on lanes 3:2 is detected when a word transfer at the aligned address carries it.
- R8: An instruction starts with the first valid transfer after reset, and with any valid transfer whose tag differs from the tag of the previous valid transfer. At most one event is raised per instruction, however many of its transfers match.
- R9: An event appears on wp_o one cycle after the transfer that caused it and lasts one cycle. wp_cnt_o rises by one on the same edge and wraps at its width.
- R10: A cycle with acc_valid_i low raises no event, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_en_i | input | 1 | Enable for the address comparator |
| addr_val_i | input | ADDR_W | Programmed address |
| addr_cond_i | input | 2 | Address condition code |
| dcmp_en_i | input | N_DCMP | Enable for each data comparator |
| dcmp_val_i | input | N_DCMP*DATA_W | Programmed data values; comparator k at [k*DATA_W +: DATA_W] |
| dcmp_cond_i | input | 2*N_DCMP | Data condition codes; comparator k at [2k +: 2] |
| dcmp_mask_i | input | N_DCMP*DATA_W/8 | Lane enables; comparator k at [k*DATA_W/8 +: DATA_W/8] |
| acc_valid_i | input | 1 | Transfer present this cycle |
| acc_addr_i | input | ADDR_W | Transfer address |
| acc_size_i | input | 2 | Transfer size code |
| acc_data_i | input | DATA_W | Transfer data, with each byte on its address lane |
| acc_tag_i | input | TAG_W | Instruction tag of the transfer |
| wp_o | output | 1 | Watchpoint event pulse |
| wp_cnt_o | output | CNT_W | Event count |

## Verification
The checker watches four things on every cycle: the counter rises by exactly the value of wp_o, no event follows an idle cycle or a cycle with all comparators disabled, and no second event is raised inside one tagged instruction. Only the bench's scenarios can show the rest, because the expected match depends on the programmed values. This covers the condition codes, the address bits dropped for each transfer size, the lane selection and all-masked behaviour, the value window, and sub-word targets seen through word loads.

// File: rtl/ls_wp_pkg.sv
package ls_wp_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GT = 2'd2,
    CMP_LT = 2'd3
  } cmp_cond_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } acc_size_e;

  function automatic logic cond_hit(cmp_cond_e c, logic eq, logic gt);
    logic r;
    unique case (c)
      CMP_EQ:  r = eq;
      CMP_NE:  r = !eq;
      CMP_GT:  r = gt;
      default: r = !eq && !gt;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ls_wp_addr_cmp.sv
module ls_wp_addr_cmp
  import ls_wp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] val_i,
  input  logic [1:0]        cond_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] lo_mask;
  logic [ADDR_W-1:0] am, vm;

  // drop the address bits that fall inside the transfer width
  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: lo_mask = '1;
      SZ_HALF: lo_mask = {{(ADDR_W-1){1'b1}}, 1'b0};
      default: lo_mask = {{(ADDR_W-2){1'b1}}, 2'b00};
    endcase
  end

  assign am    = addr_i & lo_mask;
  assign vm    = val_i & lo_mask;
  assign hit_o = !en_i || cond_hit(cmp_cond_e'(cond_i), am == vm, am > vm);

endmodule

// File: rtl/ls_wp_data_cmp.sv
module ls_wp_data_cmp
  import ls_wp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8
) (
  input  logic              en_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [1:0]        cond_i,
  input  logic [NB-1:0]     mask_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);

  logic [DATA_W-1:0] lane_m;
  logic [DATA_W-1:0] dm, vm;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign lane_m[l*8 +: 8] = {8{mask_i[l]}};
  end

  // zeroed lanes are equal on both sides, so ordering follows the enabled lanes
  assign dm    = data_i & lane_m;
  assign vm    = val_i & lane_m;
  assign hit_o = !en_i || (mask_i == '0) ||
                 cond_hit(cmp_cond_e'(cond_i), dm == vm, dm > vm);

endmodule

// File: rtl/ls_wp_evt.sv
module ls_wp_evt #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             match_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             wp_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [TAG_W-1:0] tag_q;
  logic             tag_vld_q;
  logic             rep_q;
  logic             wp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fresh;
  logic             fire;

  assign fresh = !tag_vld_q || (tag_i != tag_q);
  assign fire  = valid_i && match_i && (fresh || !rep_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q     <= '0;
      tag_vld_q <= 1'b0;
      rep_q     <= 1'b0;
      wp_q      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      wp_q <= fire;
      if (valid_i) begin
        tag_q     <= tag_i;
        tag_vld_q <= 1'b1;
        rep_q     <= (rep_q && !fresh) || match_i;
      end
      if (fire) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign wp_o  = wp_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/ls_wp_cmp.sv
module ls_wp_cmp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 16,
  parameter int N_DCMP = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         addr_en_i,
  input  logic [ADDR_W-1:0]            addr_val_i,
  input  logic [1:0]                   addr_cond_i,
  input  logic [N_DCMP-1:0]            dcmp_en_i,
  input  logic [N_DCMP*DATA_W-1:0]     dcmp_val_i,
  input  logic [2*N_DCMP-1:0]          dcmp_cond_i,
  input  logic [N_DCMP*(DATA_W/8)-1:0] dcmp_mask_i,
  input  logic                         acc_valid_i,
  input  logic [ADDR_W-1:0]            acc_addr_i,
  input  logic [1:0]                   acc_size_i,
  input  logic [DATA_W-1:0]            acc_data_i,
  input  logic [TAG_W-1:0]             acc_tag_i,
  output logic                         wp_o,
  output logic [CNT_W-1:0]             wp_cnt_o
);

  localparam int NB = DATA_W / 8;

  logic              a_hit;
  logic [N_DCMP-1:0] d_hit;
  logic              any_en;
  logic              match;

  ls_wp_addr_cmp #(.ADDR_W(ADDR_W)) i_acmp (
    .en_i   (addr_en_i),
    .val_i  (addr_val_i),
    .cond_i (addr_cond_i),
    .size_i (acc_size_i),
    .addr_i (acc_addr_i),
    .hit_o  (a_hit)
  );

  for (genvar k = 0; k < N_DCMP; k++) begin : g_dcmp
    ls_wp_data_cmp #(.DATA_W(DATA_W)) i_dcmp (
      .en_i   (dcmp_en_i[k]),
      .val_i  (dcmp_val_i[k*DATA_W +: DATA_W]),
      .cond_i (dcmp_cond_i[2*k +: 2]),
      .mask_i (dcmp_mask_i[k*NB +: NB]),
      .data_i (acc_data_i),
      .hit_o  (d_hit[k])
    );
  end

  assign any_en = addr_en_i || (|dcmp_en_i);
  assign match  = any_en && a_hit && (&d_hit);

  ls_wp_evt #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (acc_valid_i),
    .match_i (match),
    .tag_i   (acc_tag_i),
    .wp_o    (wp_o),
    .cnt_o   (wp_cnt_o)
  );

endmodule

// File: rtl/ls_wp_chk.sv
module ls_wp_chk #(
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 16,
  parameter int N_DCMP = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_en_i,
  input logic [N_DCMP-1:0] dcmp_en_i,
  input logic              acc_valid_i,
  input logic [TAG_W-1:0]  acc_tag_i,
  input logic              wp_o,
  input logic [CNT_W-1:0]  wp_cnt_o
);

  // port-side view of instruction boundaries, one cycle behind the inputs
  logic             p_v;
  logic [TAG_W-1:0] p_t;
  logic [TAG_W-1:0] l_t;
  logic             l_tv;
  logic             fired;
  logic             same;

  assign same = l_tv && (p_t == l_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_v   <= 1'b0;
      p_t   <= '0;
      l_t   <= '0;
      l_tv  <= 1'b0;
      fired <= 1'b0;
    end else begin
      p_v <= acc_valid_i;
      p_t <= acc_tag_i;
      if (p_v) begin
        l_t   <= p_t;
        l_tv  <= 1'b1;
        fired <= (same && fired) || wp_o;
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_clear : assert (!wp_o && wp_cnt_o == '0);
  end

  a_r9_cnt_follows_evt : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_cnt_o == $past(wp_cnt_o) + CNT_W'(wp_o));

  a_r10_no_evt_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acc_valid_i) |-> !wp_o);

  a_r2_no_evt_all_disabled : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!addr_en_i && dcmp_en_i == '0) |-> !wp_o);

  a_r8_one_evt_per_instr : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_v && same && fired) |-> !wp_o);

endmodule

bind ls_wp_cmp ls_wp_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W), .N_DCMP(N_DCMP)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_en_i   (addr_en_i),
  .dcmp_en_i   (dcmp_en_i),
  .acc_valid_i (acc_valid_i),
  .acc_tag_i   (acc_tag_i),
  .wp_o        (wp_o),
  .wp_cnt_o    (wp_cnt_o)
);

// File: tb/test_ls_wp_cmp.sv
`timescale 1ns/1ps
module test_ls_wp_cmp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_en = 1'b0;
  logic [31:0] addr_val = '0;
  logic [1:0]  addr_cond = '0;
  logic [1:0]  d_en = '0;
  logic [63:0] d_val = '0;
  logic [3:0]  d_cond = '0;
  logic [7:0]  d_mask = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_data = '0;
  logic [3:0]  acc_tag = '0;
  logic        wp;
  logic [15:0] wp_cnt;

  int    n_tests = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  ls_wp_cmp i_ls_wp_cmp (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_en_i(addr_en), .addr_val_i(addr_val), .addr_cond_i(addr_cond),
    .dcmp_en_i(d_en), .dcmp_val_i(d_val), .dcmp_cond_i(d_cond), .dcmp_mask_i(d_mask),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_size_i(acc_size),
    .acc_data_i(acc_data), .acc_tag_i(acc_tag),
    .wp_o(wp), .wp_cnt_o(wp_cnt)
  );

  // ---------------- reference model ----------------
  bit m_wp;
  int m_cnt;
  int m_tag;
  bit m_tv;
  bit m_rep;

  function automatic bit m_rel(logic [1:0] c, longint a, longint b);
    case (c)
      2'd0:    return a == b;
      2'd1:    return a != b;
      2'd2:    return a > b;
      default: return a < b;
    endcase
  endfunction

  function automatic bit m_addr_ok();
    int sh;
    if (!addr_en) return 1;
    sh = (acc_size == 2'd0) ? 0 : (acc_size == 2'd1) ? 1 : 2;
    return m_rel(addr_cond, longint'(acc_addr >> sh), longint'(addr_val >> sh));
  endfunction

  function automatic bit m_data_ok(int k);
    longint a = 0;
    longint b = 0;
    bit any = 0;
    if (!d_en[k]) return 1;
    for (int l = 3; l >= 0; l--) begin
      if (d_mask[k*4+l]) begin
        any = 1;
        a = a * 256 + longint'(acc_data[l*8 +: 8]);
        b = b * 256 + longint'(d_val[k*32+l*8 +: 8]);
      end
    end
    if (!any) return 1;
    return m_rel(d_cond[k*2 +: 2], a, b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit fresh, mt;
    if (!rst_n) begin
      m_wp = 0; m_cnt = 0; m_tag = 0; m_tv = 0; m_rep = 0;
    end else begin
      m_wp = 0;
      if (acc_valid) begin
        fresh = !m_tv || (int'(acc_tag) != m_tag);
        mt = (addr_en || d_en != 0) && m_addr_ok() && m_data_ok(0) && m_data_ok(1);
        if (mt && (fresh || !m_rep)) begin
          m_wp = 1;
          m_cnt = (m_cnt + 1) % 65536;
        end
        m_rep = fresh ? mt : (m_rep || mt);
        m_tag = int'(acc_tag);
        m_tv = 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (wp !== m_wp || int'(wp_cnt) != m_cnt) begin
        n_fail++;
        $display("FAIL %s: wp=%0b cnt=%0d expected wp=%0b cnt=%0d", cur_req, wp, wp_cnt, m_wp, m_cnt);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic acc(logic [31:0] a, logic [1:0] s, logic [31:0] d, logic [3:0] t);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_data = d; acc_tag = t;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  task automatic cfg_clear();
    @(negedge clk);
    acc_valid = 1'b0;
    addr_en = 0; d_en = '0; d_mask = '0; d_val = '0; d_cond = '0; addr_cond = '0;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", int'(wp), 0);
    chk("R1", int'(wp_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(wp_cnt), 0);

    // R2: nothing enabled, data and address would otherwise match
    cur_req = "R2";
    acc(32'h0, 2'd2, 32'h0, 4'd1);
    acc(32'h10, 2'd0, 32'hFF, 4'd2);
    idle(2);
    chk("R2", int'(wp_cnt), 0);

    // R3: address conditions, byte transfers
    cur_req = "R3";
    @(negedge clk);
    addr_en = 1; addr_val = 32'h200;
    for (int c = 0; c < 4; c++) begin
      addr_cond = 2'(c);
      acc(32'h1FF, 2'd0, 0, 4'(2*c));
      acc(32'h200, 2'd0, 0, 4'(2*c+1));
      acc(32'h201, 2'd0, 0, 4'(2*c));
      idle(1);
    end
    chk("R3", int'(wp_cnt), 5);

    // R4: low address bits dropped by size
    cur_req = "R4";
    c0 = int'(wp_cnt);
    @(negedge clk);
    addr_cond = 2'd0; addr_val = 32'h102;
    acc(32'h100, 2'd2, 0, 4'd1);
    acc(32'h103, 2'd2, 0, 4'd2);
    acc(32'h103, 2'd1, 0, 4'd3);
    acc(32'h100, 2'd1, 0, 4'd4);
    acc(32'h103, 2'd0, 0, 4'd5);
    acc(32'h102, 2'd0, 0, 4'd6);
    acc(32'h101, 2'd3, 0, 4'd7);
    idle(2);
    chk("R4", int'(wp_cnt) - c0, 5);

    // R5: lane masks, all-masked comparator
    cur_req = "R5";
    cfg_clear();
    c0 = int'(wp_cnt);
    d_en = 2'b01; d_mask = 8'h03; d_val[31:0] = 32'h7700_1234; d_cond = 4'd2;
    acc(32'h0, 2'd2, 32'h0000_1235, 4'd1);
    acc(32'h0, 2'd2, 32'hFFFF_1234, 4'd2);
    acc(32'h0, 2'd2, 32'h0000_1300, 4'd3);
    @(negedge clk); acc_valid = 0; d_cond = 4'd1;
    acc(32'h0, 2'd2, 32'h0000_1234, 4'd4);
    acc(32'h0, 2'd2, 32'h0000_1233, 4'd5);
    @(negedge clk); acc_valid = 0; d_mask = 8'h00;
    acc(32'h0, 2'd2, 32'h0000_1234, 4'd6);
    idle(2);
    chk("R5", int'(wp_cnt) - c0, 4);

    // R6: value window with two data comparators plus address on byte 3
    cur_req = "R6";
    cfg_clear();
    c0 = int'(wp_cnt);
    addr_en = 1; addr_val = 32'h3; addr_cond = 2'd0;
    d_en = 2'b11; d_mask = 8'h88;
    d_val = {32'h0C00_0000, 32'h0700_0000}; d_cond = {2'd3, 2'd2};
    acc(32'h3, 2'd0, 32'h0A00_0000, 4'd1);
    acc(32'h3, 2'd0, 32'h0700_0000, 4'd2);
    acc(32'h3, 2'd0, 32'h0C00_0000, 4'd3);
    acc(32'h3, 2'd0, 32'h0800_0000, 4'd4);
    acc(32'h2, 2'd0, 32'h0900_0000, 4'd5);
    acc(32'h0, 2'd2, 32'h0B11_2233, 4'd6);
    idle(2);
    chk("R6", int'(wp_cnt) - c0, 3);

    // R7: byte 2 and half-word 3:2 seen through a word load
    cur_req = "R7";
    cfg_clear();
    c0 = int'(wp_cnt);
    addr_en = 1; addr_val = 32'h42; addr_cond = 2'd0;
    d_en = 2'b01; d_mask = 8'h04; d_val[31:0] = 32'h0055_0000; d_cond = 4'd0;
    acc(32'h40, 2'd2, 32'hAA55_BBCC, 4'd1);
    acc(32'h40, 2'd2, 32'hAA56_BBCC, 4'd2);
    @(negedge clk); acc_valid = 0; d_mask = 8'h0C; d_val[31:0] = 32'hBEEF_0000;
    acc(32'h40, 2'd2, 32'hBEEF_1111, 4'd3);
    acc(32'h42, 2'd1, 32'hBEEF_0000, 4'd4);
    idle(2);
    chk("R7", int'(wp_cnt) - c0, 3);

    // R8: collapse within one tagged instruction
    cur_req = "R8";
    cfg_clear();
    c0 = int'(wp_cnt);
    d_en = 2'b01; d_mask = 8'h01; d_val[31:0] = 32'h5A; d_cond = 4'd0;
    acc(32'h0, 2'd2, 32'h00, 4'd1);
    acc(32'h4, 2'd2, 32'h5A, 4'd1);
    acc(32'h8, 2'd2, 32'h5A, 4'd1);
    acc(32'hC, 2'd2, 32'h5A, 4'd1);
    acc(32'h0, 2'd2, 32'h5A, 4'd2);
    idle(2);
    acc(32'h4, 2'd2, 32'h5A, 4'd2);
    acc(32'h0, 2'd2, 32'h5A, 4'd1);
    idle(2);
    chk("R8", int'(wp_cnt) - c0, 3);

    // R9: pulse position and width, back-to-back instructions
    cur_req = "R9";
    c0 = int'(wp_cnt);
    acc(32'h0, 2'd2, 32'h5A, 4'd3);
    @(negedge clk); acc_valid = 0;
    chk("R9", int'(wp), 1);
    @(negedge clk);
    chk("R9", int'(wp), 0);
    chk("R9", int'(wp_cnt) - c0, 1);
    acc(32'h0, 2'd2, 32'h5A, 4'd4);
    acc(32'h0, 2'd2, 32'h5A, 4'd5);
    @(negedge clk); acc_valid = 0;
    chk("R9", int'(wp), 1);
    idle(1);
    chk("R9", int'(wp_cnt) - c0, 3);

    // R10: matching inputs with valid low
    cur_req = "R10";
    c0 = int'(wp_cnt);
    @(negedge clk);
    acc_valid = 0; acc_data = 32'h5A; acc_tag = 4'd9;
    idle(4);
    chk("R10", int'(wp_cnt) - c0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule